// File: doc/BRIEF.md
# Serial Link Power and Lock Controller

This block decides when a serial link is powered, when it is still settling, and when its data may be trusted. It takes two mode-select pins and a slow reference clock, and it runs on a faster free-running system clock that treats the reference clock as an ordinary data input. Its outputs are a link-enable, a one-cycle lock-done pulse, and a data-valid gate. The serializer and the deserializer both use these outputs.

The link can be powered down in two ways, and each needs its own recovery. In the first, both mode pins are driven low. The link then drops at once, and the next power-up must wait through the full lock interval. In the second, the reference clock stops, stuck either high or low. The controller sees that no transitions are arriving and shuts the link down, but it keeps its references. When the reference clock moves again, the link recovers through a much shorter relock interval. Lock is modelled as a count of rising reference edges.

Top module: `link_pm_ctrl`

## Requirements
- R1: When both mode pins are low, the controller enters the off state on the third system clock edge after the pins change, counting two synchroniser stages and the state register. From that point, link_en and data_valid are low.
- R2: In the off state, a mode value of 01, 10 or 11 (bit 0 = mode_s1, bit 1 = mode_s2) together with a transition on ref_clk starts a lock sequence. link_en goes high while data_valid stays low.
- R3: The off state is left only if a mode pin is high and ref_clk toggles. If the mode pins are 00 and ref_clk is toggling, the controller stays off. If the mode pins are non-zero and ref_clk is stationary, the controller also stays off.
- R4: A lock sequence started from the off state goes to the active state after FULL_LOCK_EDGES rising edges of ref_clk.
- R5: lock_done is high for exactly one system clock, in the first cycle of each active period.
- R6: data_valid is high only in the active state. link_en is high in both the locking and the active states.
- R7: If ref_clk shows no transition for STALL_CYCLES system clocks while the controller is locking or active, the controller enters the stalled state and link_en and data_valid go low. This holds whether ref_clk is stuck high or stuck low.
- R8: In the stalled state, any transition on ref_clk starts a relock that needs only SHORT_LOCK_EDGES rising edges.
- R9: If the mode pins go to 00 while the controller is stalled, it goes to the off state. The next power-up then needs the full FULL_LOCK_EDGES count.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_s1 | input | 1 | Mode select bit 0, asynchronous |
| mode_s2 | input | 1 | Mode select bit 1, asynchronous |
| ref_clk | input | 1 | Reference clock, sampled as data |
| link_en | output | 1 | Link powered (locking or active) |
| lock_done | output | 1 | One-cycle pulse when a lock sequence completes |
| data_valid | output | 1 | Parallel data may be captured |

## Verification
A mode-pin power-down and a reference-clock stall can be detected in the same system clock. If that happens, the mode pins must take precedence, so the next power-up uses the full lock count and not the short one. The bench provokes this overlap by stopping ref_clk while the link is active and then dropping the mode pins at a sweep of offsets around the stall-detection point, spanning cases before, at and after the stall detector fires. Each case is judged by checking that the outputs fall, and then by measuring the number of rising reference edges in the next power-up against the full-length window.

// File: rtl/link_pm_pkg.sv
`timescale 1ns/1ps
package link_pm_pkg;

  typedef enum logic [1:0] {
    PM_OFF      = 2'd0,
    PM_LOCKING  = 2'd1,
    PM_ACTIVE   = 2'd2,
    PM_STALLED  = 2'd3
  } pm_state_t;

  // Link powered when locking or active
  function automatic logic powered(input pm_state_t s);
    return (s == PM_LOCKING) || (s == PM_ACTIVE);
  endfunction

endpackage

// File: rtl/lpm_sync.sv
`timescale 1ns/1ps
module lpm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpm_edge_mon.sv
`timescale 1ns/1ps
module lpm_edge_mon #(
  parameter int STALL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_s,
  output logic ref_any,
  output logic ref_rise,
  output logic stall_det
);

  localparam int IDLE_W = $clog2(STALL_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(STALL_CYCLES);

  logic              ref_d;
  logic [IDLE_W-1:0] idle_cnt;

  function automatic logic [IDLE_W-1:0] idle_next(input logic [IDLE_W-1:0] v,
                                                  input logic edge_seen);
    if (edge_seen)          return '0;
    else if (v >= IDLE_LIM) return IDLE_LIM;
    else                    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d    <= 1'b0;
      idle_cnt <= '0;
    end else begin
      ref_d    <= ref_s;
      idle_cnt <= idle_next(idle_cnt, ref_any);
    end
  end

  assign ref_any   = ref_s ^ ref_d;
  assign ref_rise  = ref_s & ~ref_d;
  assign stall_det = (idle_cnt == IDLE_LIM);

  assert_idle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IDLE_LIM);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_det && !ref_any) |=> stall_det);

  assert_edge_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_any |=> !stall_det);

endmodule

// File: rtl/lpm_lock_cnt.sv
`timescale 1ns/1ps
module lpm_lock_cnt #(
  parameter int FULL_LOCK_EDGES  = 256,
  parameter int SHORT_LOCK_EDGES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic use_short,
  input  logic count_en,
  output logic short_sel,
  output logic reached
);

  localparam int LOCK_W = $clog2(FULL_LOCK_EDGES + 1);
  localparam logic [LOCK_W-1:0] FULL_V  = LOCK_W'(FULL_LOCK_EDGES);
  localparam logic [LOCK_W-1:0] SHORT_V = LOCK_W'(SHORT_LOCK_EDGES);

  logic [LOCK_W-1:0] cnt;

  function automatic logic [LOCK_W-1:0] target_of(input logic short_mode);
    return short_mode ? SHORT_V : FULL_V;
  endfunction

  function automatic logic [LOCK_W-1:0] cnt_next(input logic [LOCK_W-1:0] v);
    return (v >= FULL_V) ? FULL_V : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      short_sel <= 1'b0;
    end else if (clear) begin
      cnt       <= '0;
      short_sel <= use_short;
    end else if (count_en) begin
      cnt       <= cnt_next(cnt);
    end
  end

  assign reached = (cnt >= target_of(short_sel));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_V);

  assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (short_sel == $past(use_short)) && !reached);

endmodule

// File: rtl/link_pm_ctrl.sv
`timescale 1ns/1ps
module link_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter int STALL_CYCLES     = 64,
  parameter int FULL_LOCK_EDGES  = 256,
  parameter int SHORT_LOCK_EDGES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_s1,
  input  logic mode_s2,
  input  logic ref_clk,
  output logic link_en,
  output logic lock_done,
  output logic data_valid
);

  logic [1:0] mode_s;
  logic       mode_on;
  logic       ref_s;
  logic       ref_any;
  logic       ref_rise;
  logic       stall_det;
  logic       lock_clear;
  logic       lock_short;
  logic       short_sel;
  logic       lock_reached;
  pm_state_t  state, nxt;

  lpm_sync #(.WIDTH(2), .STAGES(2)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .d({mode_s2, mode_s1}), .q(mode_s));

  lpm_sync #(.WIDTH(1), .STAGES(2)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .d(ref_clk), .q(ref_s));

  assign mode_on = |mode_s;

  lpm_edge_mon #(.STALL_CYCLES(STALL_CYCLES)) u_edge_mon (
    .clk(clk), .rst_n(rst_n), .ref_s(ref_s),
    .ref_any(ref_any), .ref_rise(ref_rise), .stall_det(stall_det));

  lpm_lock_cnt #(.FULL_LOCK_EDGES(FULL_LOCK_EDGES),
                 .SHORT_LOCK_EDGES(SHORT_LOCK_EDGES)) u_lock_cnt (
    .clk(clk), .rst_n(rst_n), .clear(lock_clear), .use_short(lock_short),
    .count_en(ref_rise && (state == PM_LOCKING)),
    .short_sel(short_sel), .reached(lock_reached));

  always_comb begin
    nxt        = state;
    lock_clear = 1'b0;
    lock_short = 1'b0;
    if (!mode_on) begin
      nxt = PM_OFF;
    end else begin
      unique case (state)
        PM_OFF: if (ref_any) begin
          nxt        = PM_LOCKING;
          lock_clear = 1'b1;
        end
        PM_LOCKING: begin
          if (stall_det)         nxt = PM_STALLED;
          else if (lock_reached) nxt = PM_ACTIVE;
        end
        PM_ACTIVE: if (stall_det) nxt = PM_STALLED;
        PM_STALLED: if (ref_any) begin
          nxt        = PM_LOCKING;
          lock_clear = 1'b1;
          lock_short = 1'b1;
        end
        default: nxt = PM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PM_OFF;
      lock_done <= 1'b0;
    end else begin
      state     <= nxt;
      lock_done <= (state == PM_LOCKING) && (nxt == PM_ACTIVE);
    end
  end

  assign link_en    = powered(state);
  assign data_valid = (state == PM_ACTIVE);

  assert_mode0_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> (state == PM_OFF) && !link_en);

  assert_lock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(lock_reached));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |=> !lock_done);

  assert_done_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |-> data_valid);

  assert_stall_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && stall_det && link_en) |=> (state == PM_STALLED));

  assert_wake_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_STALLED && mode_on && ref_any) |=> (state == PM_LOCKING) && short_sel);

  assert_off_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_OFF && mode_on && ref_any) |=> (state == PM_LOCKING) && !short_sel);

endmodule

// File: tb/link_pm_ctrl_tb.sv
`timescale 1ns/1ps
module link_pm_ctrl_tb;

  localparam int STALL = 16;
  localparam int FULL  = 10;
  localparam int SHORT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_s1 = 1'b0;
  logic mode_s2 = 1'b0;
  logic ref_clk = 1'b0;
  logic link_en, lock_done, data_valid;

  int errors = 0;
  int checks = 0;
  int rises = 0;
  int ph = 0;
  bit ref_run = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_pm_ctrl #(.STALL_CYCLES(STALL), .FULL_LOCK_EDGES(FULL),
                 .SHORT_LOCK_EDGES(SHORT)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_s1(mode_s1), .mode_s2(mode_s2),
    .ref_clk(ref_clk), .link_en(link_en), .lock_done(lock_done),
    .data_valid(data_valid));

  // Reference clock: toggles every 2 system clocks while running
  initial forever begin
    @(negedge clk);
    if (ref_run) begin
      ph++;
      if (ph >= 2) begin
        ph = 0;
        ref_clk = ~ref_clk;
        if (ref_clk) rises++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    mode_s1 = m[0];
    mode_s2 = m[1];
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Power up (or wake) and measure rising ref edges until data_valid
  task automatic measure_lock(input int target, input string req);
    int t;
    int r;
    t = 0;
    ref_run = 1'b1;
    while (!link_en && t < 60) begin cyc(1); t++; end
    check(link_en == 1'b1, "R2 link_en on power-up", int'(link_en), 1);
    check(data_valid == 1'b0, "R6 data_valid low while locking", int'(data_valid), 0);
    rises = 0;
    t = 0;
    while (!data_valid && t < 400) begin cyc(1); t++; end
    r = rises;
    check(r >= target - 1 && r <= target + 1, req, r, target);
    check(lock_done == 1'b1, "R5 lock_done on first active cycle", int'(lock_done), 1);
    cyc(1);
    check(lock_done == 1'b0, "R5 lock_done one cycle only", int'(lock_done), 0);
    check(link_en && data_valid, "R6 outputs in active", int'(link_en & data_valid), 1);
  endtask

  task automatic stop_ref_at(input bit lvl);
    while (ref_clk != lvl) cyc(1);
    ref_run = 1'b0;
  endtask

  initial begin
    #(1000000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check(!link_en && !lock_done && !data_valid, "R10 reset outputs",
          int'({link_en, lock_done, data_valid}), 0);
    rst_n = 1'b1;
    cyc(2);

    // R3: mode 00 with ref toggling stays off
    ref_run = 1'b1;
    cyc(40);
    check(link_en == 1'b0, "R3 mode 00 with toggling ref", int'(link_en), 0);
    // R3: mode non-zero with stationary ref stays off
    ref_run = 1'b0;
    for (int m = 1; m < 4; m++) begin
      set_mode(m);
      cyc(20);
      check(link_en == 1'b0 && data_valid == 1'b0, "R3 stationary ref stays off",
            int'(link_en), 0);
      set_mode(0);
      cyc(4);
    end

    // R2/R4/R5 for each powered mode, then R1 exact latency
    for (int m = 1; m < 4; m++) begin
      set_mode(m);
      measure_lock(FULL, "R4 full lock edge count");
      cyc(5);
      set_mode(0);
      cyc(2);
      check(link_en && data_valid, "R1 outputs held through sync stages",
            int'(link_en & data_valid), 1);
      cyc(1);
      check(!link_en && !data_valid && !lock_done, "R1 off on third edge",
            int'({link_en, data_valid, lock_done}), 0);
      cyc(5);
    end

    // R7/R8: stall in active, stuck low then stuck high
    for (int lvl = 0; lvl < 2; lvl++) begin
      set_mode(3);
      measure_lock(FULL, "R4 full lock before stall");
      stop_ref_at(lvl[0]);
      cyc(STALL - 2);
      check(data_valid == 1'b1, "R7 no early stall", int'(data_valid), 1);
      cyc(10);
      check(!link_en && !data_valid, "R7 stalled outputs low",
            int'({link_en, data_valid}), 0);
      cyc(30);
      check(!link_en, "R7 stays stalled without edges", int'(link_en), 0);
      measure_lock(SHORT, "R8 short relock edge count");
      cyc(5);
      set_mode(0);
      cyc(6);
    end

    // R7/R8: stall during locking
    set_mode(2);
    ref_run = 1'b1;
    while (!link_en) cyc(1);
    cyc(3);
    ref_run = 1'b0;
    cyc(STALL + 8);
    check(!link_en && !data_valid, "R7 stall while locking",
          int'({link_en, data_valid}), 0);
    measure_lock(SHORT, "R8 short relock after locking stall");

    // R9: mode 00 while stalled, then full lock
    stop_ref_at(1'b1);
    cyc(STALL + 8);
    set_mode(0);
    cyc(5);
    check(!link_en, "R9 off from stalled", int'(link_en), 0);
    set_mode(1);
    measure_lock(FULL, "R9 full lock after off from stalled");

    // Overlap sweep: mode drop around the stall detection point
    for (int off = 0; off < 8; off++) begin
      stop_ref_at(off[0]);
      cyc(STALL - 2 + off);
      set_mode(0);
      cyc(5);
      check(!link_en && !data_valid, "R1 off in stall overlap",
            int'({link_en, data_valid}), 0);
      set_mode(3);
      measure_lock(FULL, "R9 full lock after stall overlap");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule